// File: doc/BRIEF.md
# Dual-Side PWM Dead-Time Inserter

This block turns one PWM level per half-bridge side into a pair of gate enables, one for the upper switch and one for the lower switch. It never lets both enables of a side be active at once. At every change of the PWM level, both enables drop first. The enable that matches the new level then rises only after a counted number of clock cycles. The total gap for a full switching period comes from a single count, `dead_total`, which is shared by all sides.

Each side has its own signed 3-bit balance code. The code moves part of the total gap between two edges: the gap before the upper enable turns on, and the gap before the lower enable turns on. The sum of the two gaps does not change. Code zero gives an even split.

A protection controller can take over every output pair at once through `force_en`. The forced pair takes effect combinationally, in the same cycle. When the force is released, the dead time is counted again from the start.

Top module: `pwm_deadband_pair`

## Requirements
- R1: While `rst_n` is low, every `gate_hi` and `gate_lo` bit is 0.
- R2: For any side, `gate_hi` and `gate_lo` are never 1 in the same cycle, whether or not the outputs are forced.
- R3: When a side's PWM level is sampled high at edge E after being low, that side's `gate_lo` is 0 from E. If the level stays high, its `gate_hi` becomes 1 at edge E+Grise, where Grise is that side's rise gap in clock cycles.
- R4: When a side's PWM level is sampled low at edge E after being high, that side's `gate_hi` is 0 from E. If the level stays low, its `gate_lo` becomes 1 at edge E+Gfall.
- R5: Let T be `dead_total`, raised to 2 when it is below 2. Let b be the side's 3-bit code read as two's complement (3'b100 is -4, 3'b011 is +3). Then Grise = floor(T/2) + b*floor(T/8), clamped to the range 1 to T-1, and Gfall = T - Grise.
- R6: With code 3'b000, Grise = floor(T/2) and Gfall = T - floor(T/2).
- R7: Bits [2:0] of `bal_code` set side 0 and bits [5:3] set side 1. One side's code has no effect on the other side's gaps.
- R8: If the PWM level returns before the gap for the new level has run out, the enable for that level stays 0 for the whole pulse.
- R9: While `force_en` is 1, in the same cycle and for every side, `gate_lo` equals `force_lo` and `gate_hi` equals `force_hi` AND NOT `force_lo`.
- R10: After `force_en` falls, both enables of every side are 0. The enable that matches the side's PWM level becomes 1 at the gap-th edge after the last edge at which `force_en` was sampled 1.
- R11: An enable that has turned on stays on until the side's PWM level changes or `force_en` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dead_total | input | DT_W | Total dead time, in cycles, per switching period |
| bal_code | input | 3*SIDES | Signed balance code per side, side 0 in the low bits |
| pwm_in | input | SIDES | PWM level per side |
| force_en | input | 1 | Protection override enable |
| force_hi | input | 1 | Requested upper enable while forced |
| force_lo | input | 1 | Requested lower enable while forced (wins over `force_hi`) |
| gate_hi | output | SIDES | Upper switch enable per side |
| gate_lo | output | SIDES | Lower switch enable per side |

## Verification
The properties assume that `pwm_in`, `force_en` and the settings are synchronous to `clk`, and that each value is sampled once per rising edge. They assume no relation between the inputs of the two sides or between the force pair and the PWM levels. The bench changes every input at the falling edge, so each value is stable around the rising edge that samples it. The random stimulus lets `dead_total`, including values below 2, and the balance codes change while a gap is being counted. This exercises the case where the gap is re-read at each edge.

// File: rtl/pdb_pkg.sv
`timescale 1ns/1ps
package pdb_pkg;
   localparam int BAL_W     = 3;   // width of one side's balance code
   localparam int STEP_SHFT = 3;   // balance step is total >> STEP_SHFT
   localparam int MIN_TOT   = 2;   // smallest usable total gap

   typedef struct packed {
      logic hi;
      logic lo;
   } gate_pair_t;
endpackage

// File: rtl/pdb_split.sv
`timescale 1ns/1ps
module pdb_split #(
   parameter int DT_W = 8
) (
   input  logic [DT_W-1:0]            total_i,
   input  logic [pdb_pkg::BAL_W-1:0]  bal_i,
   output logic [DT_W-1:0]            rise_o,
   output logic [DT_W-1:0]            fall_o
);
   import pdb_pkg::*;
   localparam int CW = DT_W + 4;

   logic [DT_W-1:0]        teff;
   logic signed [CW-1:0]   half_s, step_s, bal_s, prod_s, raw_s, top_s;
   logic [DT_W-1:0]        rise_sel;

   always_comb begin
      teff   = (total_i < DT_W'(MIN_TOT)) ? DT_W'(MIN_TOT) : total_i;
      half_s = $signed({4'b0, teff >> 1});
      step_s = $signed({4'b0, teff >> STEP_SHFT});
      bal_s  = $signed({{(CW-BAL_W){bal_i[BAL_W-1]}}, bal_i});
      prod_s = step_s * bal_s;
      raw_s  = half_s + prod_s;
      top_s  = $signed({4'b0, teff}) - CW'(1);
      if (raw_s < CW'(1))
         rise_sel = DT_W'(1);
      else if (raw_s > top_s)
         rise_sel = top_s[DT_W-1:0];
      else
         rise_sel = raw_s[DT_W-1:0];
      rise_o = rise_sel;
      fall_o = teff - rise_sel;
   end
endmodule

// File: rtl/pdb_side.sv
`timescale 1ns/1ps
module pdb_side #(
   parameter int DT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_i,
   input  logic             hold_i,
   input  logic [DT_W-1:0]  rise_gap_i,
   input  logic [DT_W-1:0]  fall_gap_i,
   output pdb_pkg::gate_pair_t gate_o
);
   logic            lvl_q;
   logic            on_q;
   logic [DT_W-1:0] cnt_q;
   logic [DT_W-1:0] gap_now;

   assign gap_now = lvl_q ? rise_gap_i : fall_gap_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         on_q  <= 1'b0;
         cnt_q <= DT_W'(1);
      end else if (hold_i || (pwm_i != lvl_q)) begin
         lvl_q <= pwm_i;
         on_q  <= 1'b0;
         cnt_q <= DT_W'(1);
      end else if (!on_q) begin
         if (cnt_q >= gap_now)
            on_q <= 1'b1;
         else
            cnt_q <= cnt_q + DT_W'(1);
      end
   end

   assign gate_o.hi = on_q & lvl_q;
   assign gate_o.lo = on_q & ~lvl_q;
endmodule

// File: rtl/pdb_force.sv
`timescale 1ns/1ps
module pdb_force #(
   parameter int SIDES = 2
) (
   input  logic [SIDES-1:0] hi_i,
   input  logic [SIDES-1:0] lo_i,
   input  logic             force_en,
   input  logic             force_hi,
   input  logic             force_lo,
   output logic [SIDES-1:0] hi_o,
   output logic [SIDES-1:0] lo_o
);
   logic safe_hi;
   assign safe_hi = force_hi & ~force_lo;

   for (genvar s = 0; s < SIDES; s++) begin : g_mux
      assign hi_o[s] = force_en ? safe_hi  : hi_i[s];
      assign lo_o[s] = force_en ? force_lo : lo_i[s];
   end
endmodule

// File: rtl/pwm_deadband_pair.sv
`timescale 1ns/1ps
module pwm_deadband_pair #(
   parameter int DT_W  = 8,
   parameter int SIDES = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [DT_W-1:0]                   dead_total,
   input  logic [SIDES*pdb_pkg::BAL_W-1:0]   bal_code,
   input  logic [SIDES-1:0]                  pwm_in,
   input  logic                              force_en,
   input  logic                              force_hi,
   input  logic                              force_lo,
   output logic [SIDES-1:0]                  gate_hi,
   output logic [SIDES-1:0]                  gate_lo
);
   import pdb_pkg::*;

   if (DT_W < 4 || DT_W > 16) begin : g_bad_width
      $error("pwm_deadband_pair: DT_W must lie in 4..16");
   end
   if (SIDES < 1 || SIDES > 8) begin : g_bad_sides
      $error("pwm_deadband_pair: SIDES must lie in 1..8");
   end

   logic [SIDES-1:0] raw_hi, raw_lo;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      logic [DT_W-1:0] rise_gap, fall_gap;
      gate_pair_t      pair;

      pdb_split #(.DT_W(DT_W)) i_split (
         .total_i (dead_total),
         .bal_i   (bal_code[s*BAL_W +: BAL_W]),
         .rise_o  (rise_gap),
         .fall_o  (fall_gap)
      );

      pdb_side #(.DT_W(DT_W)) i_side (
         .clk        (clk),
         .rst_n      (rst_n),
         .pwm_i      (pwm_in[s]),
         .hold_i     (force_en),
         .rise_gap_i (rise_gap),
         .fall_gap_i (fall_gap),
         .gate_o     (pair)
      );

      assign raw_hi[s] = pair.hi;
      assign raw_lo[s] = pair.lo;
   end

   pdb_force #(.SIDES(SIDES)) i_force (
      .hi_i     (raw_hi),
      .lo_i     (raw_lo),
      .force_en (force_en),
      .force_hi (force_hi),
      .force_lo (force_lo),
      .hi_o     (gate_hi),
      .lo_o     (gate_lo)
   );
endmodule

// File: rtl/pdb_checker.sv
`timescale 1ns/1ps
module pdb_checker #(
   parameter int SIDES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SIDES-1:0] pwm_in,
   input logic             force_en,
   input logic             force_lo,
   input logic [SIDES-1:0] gate_hi,
   input logic [SIDES-1:0] gate_lo
);
   assert_force_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      force_en |-> (gate_lo == {SIDES{force_lo}}));

   assert_release_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!force_en && $past(force_en)) |-> (gate_hi == '0 && gate_lo == '0));

   for (genvar s = 0; s < SIDES; s++) begin : g_chk
      assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !(gate_hi[s] && gate_lo[s]));

      // R3 and R4: a sampled level change blanks both enables
      assert_change_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!force_en && !$stable(pwm_in[s])) |=> (force_en || (!gate_hi[s] && !gate_lo[s])));

      assert_hi_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!force_en && gate_hi[s]) |-> $past(pwm_in[s]));

      assert_lo_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!force_en && gate_lo[s]) |-> !$past(pwm_in[s]));

      assert_hi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (!force_en && gate_hi[s] && $stable(pwm_in[s])) |=> (force_en || gate_hi[s]));

      assert_lo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (!force_en && gate_lo[s] && $stable(pwm_in[s])) |=> (force_en || gate_lo[s]));
   end
endmodule

bind pwm_deadband_pair pdb_checker #(.SIDES(SIDES)) i_pdb_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwm_in   (pwm_in),
   .force_en (force_en),
   .force_lo (force_lo),
   .gate_hi  (gate_hi),
   .gate_lo  (gate_lo)
);

// File: tb/test_pwm_deadband_pair.sv
`timescale 1ns/1ps
module test_pwm_deadband_pair;
   localparam int DT_W  = 8;
   localparam int SIDES = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [DT_W-1:0]   tot;
   logic [5:0]        bal;
   logic [1:0]        pwm;
   logic              fen, fhi, flo;
   logic [1:0]        hs, ls;

   always #2.5 clk = ~clk;

   pwm_deadband_pair #(.DT_W(DT_W), .SIDES(SIDES)) i_pwm_deadband_pair (
      .clk(clk), .rst_n(rst_n), .dead_total(tot), .bal_code(bal),
      .pwm_in(pwm), .force_en(fen), .force_hi(fhi), .force_lo(flo),
      .gate_hi(hs), .gate_lo(ls)
   );

   int   checks = 0;
   int   errors = 0;
   logic mlvl [2];
   int   msince [2];
   logic mon [2];

   function automatic int gap_of(int t, logic [2:0] code, logic lvl);
      int te = (t < 2) ? 2 : t;
      int b  = code[2] ? int'(code) - 8 : int'(code);
      int r  = te / 2 + b * (te / 8);
      if (r < 1) r = 1;
      if (r > te - 1) r = te - 1;
      return lvl ? r : te - r;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < 2; s++) begin
         mlvl[s] = 1'b0; msince[s] = 0; mon[s] = 1'b0;
      end
   endtask

   task automatic model_edge();
      for (int s = 0; s < 2; s++) begin
         if (fen || (pwm[s] != mlvl[s])) begin
            mlvl[s] = pwm[s]; msince[s] = 0; mon[s] = 1'b0;
         end else begin
            if (msince[s] < 100000) msince[s]++;
            if (msince[s] >= gap_of(int'(tot), bal[3*s +: 3], mlvl[s])) mon[s] = 1'b1;
         end
      end
   endtask

   task automatic check_out(string tag);
      for (int s = 0; s < 2; s++) begin
         logic eh, el;
         eh = fen ? (fhi & ~flo) : (mon[s] & mlvl[s]);
         el = fen ? flo : (mon[s] & ~mlvl[s]);
         checks++;
         if (hs[s] !== eh || ls[s] !== el) begin
            errors++;
            $display("FAIL %s side %0d hi/lo actual %b%b expected %b%b at %0t",
                     tag, s, hs[s], ls[s], eh, el, $time);
         end
         checks++;
         if (hs[s] === 1'b1 && ls[s] === 1'b1) begin
            errors++;
            $display("FAIL R2 side %0d hi/lo actual 11 expected not both", s);
         end
      end
   endtask

   task automatic cyc(string tag);
      model_edge();
      @(negedge clk);
      check_out(tag);
   endtask

   task automatic expect_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // drive a new level on one side and count blanked cycles
   task automatic measure(int s, logic nl, string tag, int exp);
      int offc = 0;
      pwm[s] = nl;
      for (int k = 0; k < 300; k++) begin
         cyc(tag);
         if ((nl ? hs[s] : ls[s]) === 1'b1) break;
         offc++;
      end
      expect_int(tag, offc, exp);
   endtask

   task automatic settle(int n, string tag);
      for (int k = 0; k < n; k++) cyc(tag);
   endtask

   initial begin
      int offc;
      void'($urandom(32'd4711));
      rst_n = 1'b0; tot = 8'd16; bal = '0; pwm = '0;
      fen = 1'b0; fhi = 1'b0; flo = 1'b0;
      model_reset();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         checks++;
         if (hs !== 2'b00 || ls !== 2'b00) begin
            errors++;
            $display("FAIL R1 hi/lo actual %b/%b expected 00/00", hs, ls);
         end
      end
      rst_n = 1'b1;
      model_reset();
      settle(40, "R4");

      // R6: even split at 16
      measure(0, 1'b1, "R6", 8);
      measure(0, 1'b0, "R6", 8);
      // R5: code +3 on side 0, side 1 untouched (R7)
      bal[2:0] = 3'b011;
      measure(0, 1'b1, "R5", 14);
      measure(0, 1'b0, "R5", 2);
      measure(1, 1'b1, "R7", 8);
      measure(1, 1'b0, "R7", 8);
      // R5: code -4 saturates at one cycle
      bal[2:0] = 3'b100;
      measure(0, 1'b1, "R5", 1);
      measure(0, 1'b0, "R5", 15);
      // R6: odd total
      bal = '0; tot = 8'd7;
      measure(0, 1'b1, "R6", 3);
      measure(0, 1'b0, "R6", 4);
      // R5: total below minimum
      tot = 8'd0;
      measure(1, 1'b1, "R5", 1);
      measure(1, 1'b0, "R5", 1);

      // R8: short pulse never turns the upper enable on
      tot = 8'd20; settle(30, "R4");
      pwm[0] = 1'b1;
      offc = 0;
      for (int k = 0; k < 5; k++) begin
         cyc("R8");
         if (hs[0] === 1'b1) offc++;
      end
      pwm[0] = 1'b0;
      for (int k = 0; k < 3; k++) begin
         cyc("R8");
         if (hs[0] === 1'b1) offc++;
      end
      expect_int("R8", offc, 0);
      settle(30, "R11");

      // R9: force acts in the same cycle
      pwm = 2'b11; settle(30, "R11");
      fen = 1'b1; fhi = 1'b0; flo = 1'b1;
      #1;
      checks++;
      if (hs !== 2'b00 || ls !== 2'b11) begin
         errors++;
         $display("FAIL R9 hi/lo actual %b/%b expected 00/11", hs, ls);
      end
      settle(5, "R9");
      fhi = 1'b1; flo = 1'b1; settle(3, "R9");
      fhi = 1'b1; flo = 1'b0; settle(3, "R9");
      // R10: release, upper enable after rise gap (10) from last forced edge
      fen = 1'b0; fhi = 1'b0;
      offc = 0;
      for (int k = 0; k < 300; k++) begin
         cyc("R10");
         if (hs[0] === 1'b1) break;
         offc++;
      end
      expect_int("R10", offc, 9);

      // random phase
      for (int seg = 0; seg < 25; seg++) begin
         tot = DT_W'($urandom_range(0, 40));
         bal = 6'($urandom_range(0, 63));
         for (int k = 0; k < 300; k++) begin
            for (int s = 0; s < 2; s++)
               if ($urandom_range(0, 11) == 0) pwm[s] = ~pwm[s];
            if (!fen && $urandom_range(0, 149) == 0) begin
               fen = 1'b1; fhi = 1'($urandom_range(0, 1)); flo = 1'($urandom_range(0, 1));
            end else if (fen && $urandom_range(0, 7) == 0) begin
               fen = 1'b0;
            end
            if (k == 150 && seg[0]) bal = 6'($urandom_range(0, 63));
            cyc(fen ? "R9" : "R3");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule